// File: doc/BRIEF.md
# Multicast Hash Filter

This block is an imperfect filter for group-addressed frames. It holds a table of single bits, organised as a parameterised number of 32-bit words. Each group address the receiver wants is reduced to a short hash, and that hash picks one table bit. A received destination address whose hash lands on a set bit passes. Other addresses can share a bit with a wanted address, so the filter lets some unwanted frames through, but it never drops a wanted one.

Software-side logic loads the table through a programming port. An update opens with a start pulse, which wipes the whole table. The update then takes one 48-bit address for every cycle that has a valid strobe, and closes with a commit pulse. The receive path issues a lookup with the destination address and gets a registered accept or reject one cycle later.

A 2-bit window select chooses which bits of the two final address bytes form the hash. The same select applies to insertions and to lookups.

Top module: `mc_hash_filter`

## Requirements
- R1: After synchronous reset the table is empty, `tbl_ready` is 1 and `lkp_valid` and `lkp_accept` are 0. A lookup of any address then rejects.
- R2: `addr[47:40]` is byte 0, the first byte on the wire, and `addr[7:0]` is byte 5. The group flag is `addr[40]`. A lookup whose group flag is 0 always rejects.
- R3: The table holds REG_COUNT*32 bits, and REG_COUNT is a power of two from 8 to 128. The hash is log2(REG_COUNT*32) bits wide. Bits `hash[HW-1:5]` pick the word and `hash[4:0]` pick the bit inside it.
- R4: With base shift s = HW-8 and effective shift k = s + extra, the hash is the low HW bits of `(byte4 >> (8-k)) | (byte5 << k)`, where byte4 = `addr[15:8]` and byte5 = `addr[7:0]`.
- R5: `filt_type` 0, 1, 2 and 3 give an extra shift of 0, 1, 2 and 4. With 128 words, address 01-AA-00-12-34-56 hashes to 0x563, 0xAC6, 0x58D and 0x634 for these four values.
- R6: A cycle with `prog_start` clears every table bit at that clock edge. Unless `prog_commit` is also high, `tbl_ready` is 0 from the next cycle on.
- R7: Each insertion ORs one bit into the table, so addresses loaded in one update accumulate. An insertion is taken only in a start cycle or while `tbl_ready` is 0. At other times `prog_valid` has no effect.
- R8: `prog_commit` sets `tbl_ready` to 1 at that edge, and an insertion in the same cycle is still taken. Start, valid and commit together form a one-cycle update that leaves the table holding just that address, with `tbl_ready` staying 1.
- R9: `lkp_valid` is 1 exactly in the cycle after a cycle with `lkp_req`. `lkp_accept` is 1 only when the group flag, the hashed table bit and `tbl_ready` were all 1 in the request cycle.
- R10: While `tbl_ready` is 0, every lookup rejects, even when its table bit is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_type | input | 2 | Hash window select, used by insertions and lookups |
| prog_start | input | 1 | Opens an update and clears the table |
| prog_valid | input | 1 | Inserts `prog_addr` this cycle |
| prog_addr | input | 48 | Group address to insert |
| prog_commit | input | 1 | Closes the update |
| tbl_ready | output | 1 | 1 when no update is open |
| lkp_req | input | 1 | Lookup request |
| lkp_addr | input | 48 | Destination address to test |
| lkp_valid | output | 1 | Lookup result valid |
| lkp_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
Lookup results appear one cycle after the request: `lkp_valid` and `lkp_accept` come from one register stage fed by the request-cycle table state. `tbl_ready` changes one cycle after the start or commit edge, and a table write made at one edge becomes visible to a lookup issued in the next cycle. The bench drives every input on the falling edge and samples outputs on the following falling edge, which is half a period after the single register stage has loaded. The window-select vectors load one address and then probe neighbours that share or miss its hash by one bit, a masked high bit or the group flag.

// File: rtl/mc_hash_pkg.sv
// Shared types and helpers for the multicast hash filter.
// Assumes addresses are held with byte 0 (the first byte on the wire) in bits 47:40.
package mc_hash_pkg;

    typedef logic [47:0] mac_addr_t;

    typedef enum logic [1:0] {
        WIN_BASE  = 2'd0,
        WIN_PLUS1 = 2'd1,
        WIN_PLUS2 = 2'd2,
        WIN_PLUS4 = 2'd3
    } win_sel_e;

    // Extra left shift applied on top of the base window position.
    function automatic int win_extra(input logic [1:0] sel);
        case (win_sel_e'(sel))
            WIN_PLUS1: return 1;
            WIN_PLUS2: return 2;
            WIN_PLUS4: return 4;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/mc_hash_calc.sv
// Combinational hash of the two final address bytes.
// Input tail[15:8] is byte 4 and tail[7:0] is byte 5.
// Assumes 8 <= HASH_W <= 12, so that the effective shift never exceeds 8.
module mc_hash_calc
    import mc_hash_pkg::*;
#(
    parameter int HASH_W = 12
) (
    input  logic [15:0]       tail,
    input  logic [1:0]        win_sel,
    output logic [HASH_W-1:0] hash
);

    localparam int BASE_SHIFT = HASH_W - 8;

    int                shift;
    logic [HASH_W-1:0] lo_part;
    logic [HASH_W-1:0] hi_part;

    // Place byte 4 and byte 5 into the selected window; truncation is the mask.
    always_comb begin
        shift   = BASE_SHIFT + win_extra(win_sel);
        lo_part = HASH_W'(tail[15:8]) >> (8 - shift);
        hi_part = HASH_W'(tail[7:0]) << shift;
        hash    = lo_part | hi_part;
    end

endmodule

// File: rtl/mc_hash_ctrl.sv
// Update sequencing: tracks whether an update is open and gates table writes.
// Assumes start, valid and commit are single-cycle strobes from one master.
module mc_hash_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic commit,
    output logic ready,
    output logic wr_clr,
    output logic wr_en
);

    logic ready_q;

    // Ready drops when an update opens and returns when it closes; commit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
        end else if (commit) begin
            ready_q <= 1'b1;
        end else if (start) begin
            ready_q <= 1'b0;
        end
    end

    // Insertions count only inside an update or in the cycle that opens one.
    always_comb begin
        wr_clr = start;
        wr_en  = valid && (start || !ready_q);
    end

    assign ready = ready_q;

endmodule

// File: rtl/mc_hash_table.sv
// Bit table of REG_COUNT 32-bit words with a whole-table clear, a single-bit set and one read port.
// A clear and a set in the same cycle leave only the new bit. Reads return the state before the edge.
// Assumes REG_COUNT is a power of two, so the word index needs no wrap logic.
module mc_hash_table #(
    parameter int REG_COUNT = 128,
    parameter int IDX_W     = $clog2(REG_COUNT),
    parameter int HASH_W    = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [HASH_W-1:0] set_hash,
    input  logic [HASH_W-1:0] rd_hash,
    output logic              rd_bit
);

    logic [31:0] words [REG_COUNT];
    logic [31:0] set_mask;
    logic [IDX_W-1:0] set_idx;

    // Decode the bit position being inserted.
    always_comb begin
        set_idx  = set_hash[HASH_W-1:5];
        set_mask = 32'd1 << set_hash[4:0];
    end

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_word
        logic        hit;
        logic [31:0] word_q;

        assign hit = set_en && (set_idx == IDX_W'(r));

        // One table word: cleared by reset or update start, then bits ORed in.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clr || hit) begin
                word_q <= (clr ? 32'd0 : word_q) | (hit ? set_mask : 32'd0);
            end
        end

        assign words[r] = word_q;
    end

    // Read the selected bit of the selected word.
    assign rd_bit = words[rd_hash[HASH_W-1:5]][rd_hash[4:0]];

endmodule

// File: rtl/mc_hash_lookup.sv
// Registers the lookup verdict one cycle after the request.
// Assumes hit reflects the table state in the request cycle.
module mc_hash_lookup (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic group,
    input  logic hit,
    input  logic ready,
    output logic res_valid,
    output logic res_accept
);

    // Verdict stage: accept needs a group address, a set bit and a closed update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid  <= req;
            res_accept <= req && group && hit && ready;
        end
    end

endmodule

// File: rtl/mc_hash_filter.sv
// Top of the multicast hash filter: programming port, bit table and lookup port.
// Assumes REG_COUNT is a power of two from 8 to 128, so the hash is 8 to 12 bits wide.
module mc_hash_filter
    import mc_hash_pkg::*;
#(
    parameter int REG_COUNT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  filt_type,
    input  logic        prog_start,
    input  logic        prog_valid,
    input  logic [47:0] prog_addr,
    input  logic        prog_commit,
    output logic        tbl_ready,
    input  logic        lkp_req,
    input  logic [47:0] lkp_addr,
    output logic        lkp_valid,
    output logic        lkp_accept
);

    localparam int IDX_W  = $clog2(REG_COUNT);
    localparam int HASH_W = IDX_W + 5;
    localparam int N_PORT = 2;

    logic [15:0]       calc_tail [N_PORT];
    logic [HASH_W-1:0] calc_hash [N_PORT];
    logic              wr_clr;
    logic              wr_en;
    logic              tbl_bit;
    logic              unused_addr_bits;

    // Port 0 hashes the insert address, port 1 hashes the lookup address.
    assign calc_tail[0] = prog_addr[15:0];
    assign calc_tail[1] = lkp_addr[15:0];

    for (genvar p = 0; p < N_PORT; p++) begin : g_hash
        mc_hash_calc #(.HASH_W(HASH_W)) u_calc (
            .tail    (calc_tail[p]),
            .win_sel (filt_type),
            .hash    (calc_hash[p])
        );
    end

    mc_hash_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (prog_start),
        .valid  (prog_valid),
        .commit (prog_commit),
        .ready  (tbl_ready),
        .wr_clr (wr_clr),
        .wr_en  (wr_en)
    );

    mc_hash_table #(.REG_COUNT(REG_COUNT)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_clr),
        .set_en   (wr_en),
        .set_hash (calc_hash[0]),
        .rd_hash  (calc_hash[1]),
        .rd_bit   (tbl_bit)
    );

    mc_hash_lookup u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (lkp_req),
        .group      (lkp_addr[40]),
        .hit        (tbl_bit),
        .ready      (tbl_ready),
        .res_valid  (lkp_valid),
        .res_accept (lkp_accept)
    );

    // Address bits that take no part in hashing or in the group test.
    assign unused_addr_bits = ^{prog_addr[47:16], lkp_addr[47:41], lkp_addr[39:16]};

endmodule

// File: rtl/mc_hash_filter_chk.sv
// Protocol and timing checks for mc_hash_filter, attached by bind.
// Assumes it observes only the top-level ports.
module mc_hash_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_start,
    input logic prog_commit,
    input logic tbl_ready,
    input logic lkp_req,
    input logic lkp_group,
    input logic lkp_valid,
    input logic lkp_accept
);

    // R6: an update that opens without a commit takes ready low.
    a_r6_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start && !prog_commit |=> !tbl_ready);

    // R6: ready does not move without a start or a commit.
    a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_start && !prog_commit |=> $stable(tbl_ready));

    // R8: a commit always leaves ready high.
    a_r8_commit_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
        prog_commit |=> tbl_ready);

    // R9: every request yields a result one cycle later.
    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |=> lkp_valid);

    // R9: no result without a request.
    a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_req |=> !lkp_valid);

    // R9: accept appears only together with valid.
    a_r9_accept_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_accept |-> lkp_valid);

    // R10: a lookup while an update is open is rejected.
    a_r10_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req && !tbl_ready |=> !lkp_accept);

    // R2: an individual (non-group) destination is rejected.
    a_r2_individual_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req && !lkp_group |=> !lkp_accept);

endmodule

bind mc_hash_filter mc_hash_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_start  (prog_start),
    .prog_commit (prog_commit),
    .tbl_ready   (tbl_ready),
    .lkp_req     (lkp_req),
    .lkp_group   (lkp_addr[40]),
    .lkp_valid   (lkp_valid),
    .lkp_accept  (lkp_accept)
);

// File: tb/mc_hash_filter_tb.sv
// Self-checking bench for mc_hash_filter: a vector table for the hash windows, then directed tests.
module mc_hash_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  filt_type = 2'd0;
    logic        prog_start = 1'b0;
    logic        prog_valid = 1'b0;
    logic [47:0] prog_addr = '0;
    logic        prog_commit = 1'b0;
    logic        tbl_ready;
    logic        lkp_req = 1'b0;
    logic [47:0] lkp_addr = '0;
    logic        lkp_valid;
    logic        lkp_accept;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mc_hash_filter #(.REG_COUNT(128)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .filt_type   (filt_type),
        .prog_start  (prog_start),
        .prog_valid  (prog_valid),
        .prog_addr   (prog_addr),
        .prog_commit (prog_commit),
        .tbl_ready   (tbl_ready),
        .lkp_req     (lkp_req),
        .lkp_addr    (lkp_addr),
        .lkp_valid   (lkp_valid),
        .lkp_accept  (lkp_accept)
    );

    // Example group address: hashes 0x563 / 0xAC6 / 0x58D / 0x634 for window selects 0..3.
    localparam logic [47:0] EX_ADDR = 48'h01AA_0012_3456;

    typedef struct packed {
        logic [1:0]  ft;
        logic [47:0] probe;
        logic        exp;
    } vec_t;

    // Program EX_ADDR under ft, then probe. Expected verdicts follow the R4/R5 formula.
    localparam vec_t VECS [12] = '{
        '{2'd0, 48'h01AA_0012_3456, 1'b1},  // same address, hash 0x563
        '{2'd0, 48'h0100_5E00_3F56, 1'b1},  // low nibble of byte4 dropped
        '{2'd0, 48'h0100_5E00_4456, 1'b0},  // 0x564: same word, next bit (R3)
        '{2'd1, 48'h0100_5E00_3756, 1'b1},  // byte4>>3 still 6
        '{2'd1, 48'h0100_5E00_34D6, 1'b1},  // top bit of byte5 masked off
        '{2'd1, 48'h0100_5E00_3C56, 1'b0},  // 0xAC7
        '{2'd2, 48'h0100_5E00_3756, 1'b1},  // byte4>>2 still 0xD
        '{2'd2, 48'h0100_5E00_3496, 1'b1},  // top two bits of byte5 masked
        '{2'd2, 48'h0100_5E00_3856, 1'b0},  // 0x58E
        '{2'd3, 48'h0100_5E00_3416, 1'b1},  // high nibble of byte5 masked
        '{2'd3, 48'h0100_5E00_3556, 1'b0},  // 0x635
        '{2'd3, 48'h00AA_0012_3456, 1'b0}   // group flag clear (R2)
    };

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic open_update(input logic [1:0] ft);
        filt_type  = ft;
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic insert(input logic [47:0] a);
        prog_valid = 1'b1;
        prog_addr  = a;
        @(negedge clk);
        prog_valid = 1'b0;
    endtask

    task automatic close_update();
        prog_commit = 1'b1;
        @(negedge clk);
        prog_commit = 1'b0;
    endtask

    // Request in one cycle; the verdict is sampled at the next falling edge.
    task automatic probe(input logic [47:0] a, input logic exp, input string tag);
        lkp_req  = 1'b1;
        lkp_addr = a;
        @(negedge clk);
        lkp_req = 1'b0;
        check_bit({tag, " valid"}, lkp_valid, 1'b1);
        check_bit({tag, " accept"}, lkp_accept, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    localparam logic [47:0] A_ADDR = 48'h0100_5E00_0001;  // type 0 hash 0x010
    localparam logic [47:0] B_ADDR = 48'h0100_5E00_00F0;  // type 0 hash 0xF00
    localparam logic [47:0] C_ADDR = 48'h0100_5E00_0077;  // type 0 hash 0x770

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1 ready", tbl_ready, 1'b1);
        check_bit("R1 valid", lkp_valid, 1'b0);
        check_bit("R1 accept", lkp_accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        filt_type = 2'd0;
        probe(EX_ADDR, 1'b0, "R1 empty table");

        // R3/R4/R5 vector walk
        for (int i = 0; i < 12; i++) begin
            open_update(VECS[i].ft);
            insert(EX_ADDR);
            close_update();
            probe(VECS[i].probe, VECS[i].exp, $sformatf("R3/R4/R5 vector %0d", i));
        end

        // R6: a new update wipes the previous contents
        open_update(2'd0);
        insert(A_ADDR);
        close_update();
        open_update(2'd0);
        insert(B_ADDR);
        close_update();
        probe(A_ADDR, 1'b0, "R6 old entry cleared");
        probe(B_ADDR, 1'b1, "R6 new entry present");

        // R7: insertions accumulate
        open_update(2'd0);
        insert(A_ADDR);
        insert(B_ADDR);
        close_update();
        probe(A_ADDR, 1'b1, "R7 first of two");
        probe(B_ADDR, 1'b1, "R7 second of two");

        // R10: lookups reject while the update is open
        open_update(2'd0);
        insert(A_ADDR);
        check_bit("R6 ready low in update", tbl_ready, 1'b0);
        probe(A_ADDR, 1'b0, "R10 busy lookup");
        close_update();
        check_bit("R8 ready after commit", tbl_ready, 1'b1);
        probe(A_ADDR, 1'b1, "R10 after commit");

        // R7: an insertion outside an update is ignored
        insert(C_ADDR);
        probe(C_ADDR, 1'b0, "R7 stray insert ignored");
        probe(A_ADDR, 1'b1, "R7 table kept");

        // R8: start, valid and commit in one cycle
        prog_start  = 1'b1;
        prog_valid  = 1'b1;
        prog_commit = 1'b1;
        prog_addr   = C_ADDR;
        @(negedge clk);
        prog_start  = 1'b0;
        prog_valid  = 1'b0;
        prog_commit = 1'b0;
        check_bit("R8 one-cycle update ready", tbl_ready, 1'b1);
        probe(C_ADDR, 1'b1, "R8 one-cycle entry");
        probe(A_ADDR, 1'b0, "R8 one-cycle cleared");

        // R2: same hash but individual address
        probe(48'h0000_5E00_0077, 1'b0, "R2 individual address");

        // R9: no result without a request
        @(negedge clk);
        check_bit("R9 idle valid", lkp_valid, 1'b0);
        check_bit("R9 idle accept", lkp_accept, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule